// File: doc/BRIEF.md
# Two-Word Serial Configuration Loader for a Frequency Synthesizer

This block holds the configuration of an integer-N synthesizer's divider chain. A three-wire serial port fills it: a data line, a shift clock, and a latch strobe. A fourth line, the option-write level, decides which of two internal shift buffers the shared data and clock pair feeds.

When that level is low, bits go to a 20-bit divider buffer. The buffer is committed on the rising edge of the latch strobe. When the level is high, bits go to an 8-bit option buffer, which is committed when the level falls. The committed divider word is unpacked into a 6-bit reference divider value, a 9-bit main divider value and a 4-bit swallow count.

A mode input can instead take the three divider values straight from parallel pins. In that mode prescaler bypass is never allowed. The option bits reach the rest of the chip only while an active-low option enable is held. Three of those option bits pick a test signal for a single observation output.

All serial lines are sampled by a fast system clock, and edges are detected on the samples. One system-clock period must therefore be shorter than any high or low time on the serial lines.

Top module: `pllcfg_loader`

## Requirements
- R1: While reset is asserted and after it is released, `divR`, `divM`, `divA` (serial mode) and `enhBits` are zero and `dout` is 0.
- R2: With `enhWrite` low, each rising edge of `serClk` shifts `serData` into the divider buffer. A rising edge of `freqLatch` commits the last 20 bits, where the first-sent bit is B0. The field layout is as follows:
  - B0 and B1 are R bits 5 and 4.
  - B2 and B3 are M bits 8 and 7, and B4 is ignored.
  - B5..B11 are M bits 6 down to 0.
  - B12..B15 are R bits 3 down to 0.
  - B16..B19 are A bits 3 down to 0.
- R3: Shifting without a `freqLatch` rising edge leaves `divR`, `divM` and `divA` unchanged.
- R4: With `enhWrite` high, `serClk` rising edges shift into the 8-bit option buffer, first-sent bit B0. The falling edge of `enhWrite` commits it, with `enhBits[i]` = Bi. Option shifts never alter the divider buffer, so a new `freqLatch` edge recommits the earlier divider word.
- R5: While `enhEnN` is high, `enhBits` is all zero and `dout` is 0. When `enhEnN` returns low, the committed option bits reappear.
- R6: While `directMode` is high, `divR`, `divM` and `divA` equal `pinR`, `pinM` and `pinA`, and `enhBits[7]` (prescaler bypass) reads 0. When `directMode` returns low, the committed serial values and the bypass bit return.
- R7: `dout` follows `fpIn` when only `enhBits[2]` is set among bits 2, 5 and 6. It follows `mselIn` when only bit 5 is set, and `fcIn` when only bit 6 is set. When none or more than one of these bits is set, `dout` is 0.
- R8: When a `freqLatch` rising edge and a divider-buffer shift edge are seen in the same system-clock cycle, the commit takes the buffer as it was before that shift. The shift still takes place.
- R9: When more than 20 bits are shifted before a commit, only the last 20 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | input | 1 | Serial data bit |
| serClk | input | 1 | Serial shift clock (rising edge shifts) |
| freqLatch | input | 1 | Divider word commit strobe (rising edge) |
| enhWrite | input | 1 | High: shifts feed the option buffer; falling edge commits it |
| directMode | input | 1 | High: divider values come from the parallel pins |
| pinR | input | 6 | Parallel reference divider value |
| pinM | input | 9 | Parallel main divider value |
| pinA | input | 4 | Parallel swallow count |
| enhEnN | input | 1 | Active-low enable for the option bits |
| fpIn | input | 1 | Main divider output, observable on dout |
| mselIn | input | 1 | Modulus select, observable on dout |
| fcIn | input | 1 | Reference divider output, observable on dout |
| divR | output | 6 | Active reference divider value |
| divM | output | 9 | Active main divider value |
| divA | output | 4 | Active swallow count |
| enhBits | output | 8 | Active option bits, bit i = Bi |
| dout | output | 1 | Selected observation signal |

## Verification
The two functions that can fall in the same cycle are a divider-word commit and a divider-buffer shift. The bench provokes this by raising the serial clock and the latch strobe at the same instant after a full word has been sent.

It judges the result in two steps. First, the committed fields must equal the word sent before the extra bit. Second, a further strobe must expose the buffer shifted by exactly one position, with the new bit at B19.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

  localparam int FREQ_W = 20;
  localparam int ENH_W  = 8;
  localparam int R_W    = 6;
  localparam int M_W    = 9;
  localparam int A_W    = 4;

  // positions in serial order (bit i = Bi, first sent is B0)
  localparam int POS_R5    = 0;
  localparam int POS_R4    = 1;
  localparam int POS_M8    = 2;
  localparam int POS_M7    = 3;
  localparam int POS_SPARE = 4;
  localparam int POS_MLO   = 5;   // M6 .. M0
  localparam int POS_RLO   = 12;  // R3 .. R0
  localparam int POS_A     = 16;  // A3 .. A0
  localparam int M_LO_W    = M_W - 2;
  localparam int R_LO_W    = R_W - 2;

  // option bit positions
  localparam int OPT_FP   = 2;
  localparam int OPT_PD   = 3;
  localparam int OPT_LOAD = 4;
  localparam int OPT_MSEL = 5;
  localparam int OPT_FC   = 6;
  localparam int OPT_BYP  = 7;

  // indices of watched serial lines in the control
  localparam int LINE_CLK   = 0;
  localparam int LINE_LATCH = 1;
  localparam int LINE_ENH   = 2;
  localparam int NUM_LINES  = 3;

  typedef struct packed {
    logic dataBit;
    logic shiftFreq;
    logic shiftEnh;
    logic commitFreq;
    logic commitEnh;
  } strobe_t;

endpackage

// File: rtl/pllcfg_ctrl.sv
module pllcfg_ctrl
  import pllcfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    serData,
  input  logic    serClk,
  input  logic    freqLatch,
  input  logic    enhWrite,
  output strobe_t strb
);

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncQ;
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] riseSeen;
  logic                 dataQ;

  assign rawLines[LINE_CLK]   = serClk;
  assign rawLines[LINE_LATCH] = freqLatch;
  assign rawLines[LINE_ENH]   = enhWrite;

  // one sample stage and one history stage per watched line
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[g] <= 1'b0;
        prevQ[g] <= 1'b0;
      end else begin
        syncQ[g] <= rawLines[g];
        prevQ[g] <= syncQ[g];
      end
    end
    assign riseSeen[g] = syncQ[g] & ~prevQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataQ <= 1'b0;
    else       dataQ <= serData;
  end

  always_comb begin
    strb.dataBit    = dataQ;
    strb.shiftFreq  = riseSeen[LINE_CLK] & ~syncQ[LINE_ENH];
    strb.shiftEnh   = riseSeen[LINE_CLK] &  syncQ[LINE_ENH];
    strb.commitFreq = riseSeen[LINE_LATCH];
    strb.commitEnh  = prevQ[LINE_ENH] & ~syncQ[LINE_ENH];
  end

endmodule

// File: rtl/pllcfg_datapath.sv
module pllcfg_datapath
  import pllcfg_pkg::*;
#(
  parameter int FW = FREQ_W,
  parameter int EW = ENH_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strb,
  output logic [FW-1:0]  freqWord,
  output logic [EW-1:0]  enhWord,
  output logic [R_W-1:0] serR,
  output logic [M_W-1:0] serM,
  output logic [A_W-1:0] serA
);

  logic [FW-1:0] freqBuf;
  logic [EW-1:0] enhBuf;
  logic          unusedSpare;

  // shift toward bit 0 so that after a full word bit i holds Bi
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqBuf <= '0;
    end else if (strb.shiftFreq) begin
      freqBuf <= {strb.dataBit, freqBuf[FW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enhBuf <= '0;
    end else if (strb.shiftEnh) begin
      enhBuf <= {strb.dataBit, enhBuf[EW-1:1]};
    end
  end

  // commits copy the buffer contents from before any same-cycle shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqWord <= '0;
    end else if (strb.commitFreq) begin
      freqWord <= freqBuf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enhWord <= '0;
    end else if (strb.commitEnh) begin
      enhWord <= enhBuf;
    end
  end

  // field unpacking
  assign serR[R_W-1] = freqWord[POS_R5];
  assign serR[R_W-2] = freqWord[POS_R4];
  assign serM[M_W-1] = freqWord[POS_M8];
  assign serM[M_W-2] = freqWord[POS_M7];
  assign unusedSpare = freqWord[POS_SPARE];

  for (genvar k = 0; k < M_LO_W; k++) begin : gMlo
    assign serM[M_LO_W-1-k] = freqWord[POS_MLO+k];
  end

  for (genvar k = 0; k < R_LO_W; k++) begin : gRlo
    assign serR[R_LO_W-1-k] = freqWord[POS_RLO+k];
  end

  for (genvar k = 0; k < A_W; k++) begin : gA
    assign serA[A_W-1-k] = freqWord[POS_A+k];
  end

endmodule

// File: rtl/pllcfg_outsel.sv
module pllcfg_outsel
  import pllcfg_pkg::*;
(
  input  logic [R_W-1:0]   serR,
  input  logic [M_W-1:0]   serM,
  input  logic [A_W-1:0]   serA,
  input  logic [R_W-1:0]   pinR,
  input  logic [M_W-1:0]   pinM,
  input  logic [A_W-1:0]   pinA,
  input  logic             directMode,
  input  logic             enhEnN,
  input  logic [ENH_W-1:0] enhWord,
  input  logic             fpIn,
  input  logic             mselIn,
  input  logic             fcIn,
  output logic [R_W-1:0]   divR,
  output logic [M_W-1:0]   divM,
  output logic [A_W-1:0]   divA,
  output logic [ENH_W-1:0] enhBits,
  output logic             dout
);

  logic [2:0] srcSel;

  always_comb begin
    if (directMode) begin
      divR = pinR;
      divM = pinM;
      divA = pinA;
    end else begin
      divR = serR;
      divM = serM;
      divA = serA;
    end
  end

  always_comb begin
    if (enhEnN) begin
      enhBits = '0;
    end else begin
      enhBits          = enhWord;
      enhBits[OPT_BYP] = enhWord[OPT_BYP] & ~directMode;
    end
  end

  assign srcSel = {enhBits[OPT_FC], enhBits[OPT_MSEL], enhBits[OPT_FP]};

  always_comb begin
    case (srcSel)
      3'b001:  dout = fpIn;
      3'b010:  dout = mselIn;
      3'b100:  dout = fcIn;
      default: dout = 1'b0;
    endcase
  end

endmodule

// File: rtl/pllcfg_loader.sv
module pllcfg_loader
  import pllcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             serClk,
  input  logic             freqLatch,
  input  logic             enhWrite,
  input  logic             directMode,
  input  logic [R_W-1:0]   pinR,
  input  logic [M_W-1:0]   pinM,
  input  logic [A_W-1:0]   pinA,
  input  logic             enhEnN,
  input  logic             fpIn,
  input  logic             mselIn,
  input  logic             fcIn,
  output logic [R_W-1:0]   divR,
  output logic [M_W-1:0]   divM,
  output logic [A_W-1:0]   divA,
  output logic [ENH_W-1:0] enhBits,
  output logic             dout
);

  strobe_t           strb;
  logic [FREQ_W-1:0] freqWord;
  logic [ENH_W-1:0]  enhWord;
  logic [R_W-1:0]    serR;
  logic [M_W-1:0]    serM;
  logic [A_W-1:0]    serA;

  pllcfg_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .serData   (serData),
    .serClk    (serClk),
    .freqLatch (freqLatch),
    .enhWrite  (enhWrite),
    .strb      (strb)
  );

  pllcfg_datapath #(.FW(FREQ_W), .EW(ENH_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .freqWord (freqWord),
    .enhWord  (enhWord),
    .serR     (serR),
    .serM     (serM),
    .serA     (serA)
  );

  pllcfg_outsel uOut (
    .serR       (serR),
    .serM       (serM),
    .serA       (serA),
    .pinR       (pinR),
    .pinM       (pinM),
    .pinA       (pinA),
    .directMode (directMode),
    .enhEnN     (enhEnN),
    .enhWord    (enhWord),
    .fpIn       (fpIn),
    .mselIn     (mselIn),
    .fcIn       (fcIn),
    .divR       (divR),
    .divM       (divM),
    .divA       (divA),
    .enhBits    (enhBits),
    .dout       (dout)
  );

endmodule

// File: rtl/pllcfg_loader_chk.sv
module pllcfg_loader_chk
  import pllcfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           strb,
  input logic [FREQ_W-1:0] freqBuf,
  input logic [FREQ_W-1:0] freqWord,
  input logic [ENH_W-1:0]  enhBuf,
  input logic [ENH_W-1:0]  enhWord,
  input logic [ENH_W-1:0]  enhBits,
  input logic              directMode,
  input logic              enhEnN,
  input logic              dout
);

  // R2 and R8: commit takes the pre-shift buffer
  a_r2_freq_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitFreq |=> freqWord == $past(freqBuf));

  a_r3_freq_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitFreq |=> $stable(freqWord));

  a_r4_enh_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitEnh |=> enhWord == $past(enhBuf));

  a_r4_enh_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitEnh |=> $stable(enhWord));

  a_r4_buf_isolation: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEnh |=> $stable(freqBuf));

  a_r5_gate: assert property (@(posedge clk) disable iff (!rstN)
    enhEnN |-> (enhBits == '0 && !dout));

  a_r6_no_bypass: assert property (@(posedge clk) disable iff (!rstN)
    directMode |-> !enhBits[OPT_BYP]);

  a_r7_conflict: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({enhBits[OPT_FC], enhBits[OPT_MSEL], enhBits[OPT_FP]}) > 1) |-> !dout);

endmodule

bind pllcfg_loader pllcfg_loader_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (strb),
  .freqBuf    (uDp.freqBuf),
  .freqWord   (freqWord),
  .enhBuf     (uDp.enhBuf),
  .enhWord    (enhWord),
  .enhBits    (enhBits),
  .directMode (directMode),
  .enhEnN     (enhEnN),
  .dout       (dout)
);

// File: tb/sim_pllcfg_loader.sv
`timescale 1ns/1ps
module sim_pllcfg_loader;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serData = 1'b0, serClk = 1'b0, freqLatch = 1'b0, enhWrite = 1'b0;
  logic       directMode = 1'b0, enhEnN = 1'b0;
  logic [5:0] pinR = '0;
  logic [8:0] pinM = '0;
  logic [3:0] pinA = '0;
  logic       fpIn = 1'b0, mselIn = 1'b0, fcIn = 1'b0;
  logic [5:0] divR;
  logic [8:0] divM;
  logic [3:0] divA;
  logic [7:0] enhBits;
  logic       dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pllcfg_loader u0 (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .freqLatch(freqLatch), .enhWrite(enhWrite), .directMode(directMode),
    .pinR(pinR), .pinM(pinM), .pinA(pinA), .enhEnN(enhEnN),
    .fpIn(fpIn), .mselIn(mselIn), .fcIn(fcIn),
    .divR(divR), .divM(divM), .divA(divA), .enhBits(enhBits), .dout(dout)
  );

  // {R, M, A, option byte}
  localparam logic [26:0] VEC [0:5] = '{
    {6'h2A, 9'h155, 4'h9, 8'h00},
    {6'h3F, 9'h1FF, 4'hF, 8'h10},
    {6'h01, 9'h001, 4'h0, 8'h08},
    {6'h15, 9'h0AA, 4'h6, 8'h90},
    {6'h00, 9'h100, 4'h8, 8'h04},
    {6'h20, 9'h080, 4'h1, 8'h40}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] encodeBits(logic [5:0] r, logic [8:0] m, logic [3:0] a);
    logic [19:0] b;
    b = '0;
    b[0] = r[5]; b[1] = r[4]; b[2] = m[8]; b[3] = m[7]; b[4] = 1'b0;
    for (int k = 0; k < 7; k++) b[5+k] = m[6-k];
    for (int k = 0; k < 4; k++) begin
      b[12+k] = r[3-k];
      b[16+k] = a[3-k];
    end
    return b;
  endfunction

  function automatic logic [18:0] decodeBits(logic [19:0] b);
    logic [5:0] r; logic [8:0] m; logic [3:0] a;
    r[5] = b[0]; r[4] = b[1]; m[8] = b[2]; m[7] = b[3];
    for (int k = 0; k < 7; k++) m[6-k] = b[5+k];
    for (int k = 0; k < 4; k++) begin
      r[3-k] = b[12+k];
      a[3-k] = b[16+k];
    end
    return {r, m, a};
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(input logic d);
    @(negedge clk); serData = d;
    waitN(2); serClk = 1'b1;
    waitN(2); serClk = 1'b0;
  endtask

  task automatic sendFreq(input logic [19:0] b);
    for (int i = 0; i < 20; i++) shiftBit(b[i]);
    waitN(3);
  endtask

  task automatic pulseLatch();
    @(negedge clk); freqLatch = 1'b1;
    waitN(2); freqLatch = 1'b0;
    waitN(3);
  endtask

  task automatic sendEnh(input logic [7:0] e);
    @(negedge clk); enhWrite = 1'b1;
    waitN(2);
    for (int i = 0; i < 8; i++) shiftBit(e[i]);
    waitN(2); enhWrite = 1'b0;
    waitN(4);
  endtask

  function automatic logic expDout(logic [7:0] e, logic fp, logic ms, logic fc);
    case ({e[6], e[5], e[2]})
      3'b001:  return fp;
      3'b010:  return ms;
      3'b100:  return fc;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [18:0] prevFields;
    logic [19:0] b;
    logic [18:0] e19;

    // R1: reset state
    waitN(3);
    chk("R1 divR in reset", divR, 0);
    chk("R1 enhBits in reset", enhBits, 0);
    rstN = 1'b1;
    waitN(3);
    chk("R1 fields after reset", {divR, divM, divA}, 0);
    chk("R1 dout after reset", dout, 0);

    // table walk: R2, R3, R4, R7
    fpIn = 1'b1; fcIn = 1'b1; mselIn = 1'b0;
    prevFields = '0;
    for (int v = 0; v < 6; v++) begin
      sendFreq(encodeBits(VEC[v][26:21], VEC[v][20:12], VEC[v][11:8]));
      chk("R3 fields hold before latch", {divR, divM, divA}, prevFields);
      pulseLatch();
      chk("R2 fields after latch", {divR, divM, divA}, VEC[v][26:8]);
      sendEnh(VEC[v][7:0]);
      chk("R4 option bits committed", enhBits, VEC[v][7:0]);
      chk("R7 dout source", dout, expDout(VEC[v][7:0], fpIn, mselIn, fcIn));
      prevFields = VEC[v][26:8];
    end

    // R4: option shifts leave divider buffer intact
    pulseLatch();
    chk("R4 divider buffer untouched by option shifts", {divR, divM, divA}, prevFields);

    // R5: gate
    enhEnN = 1'b1; waitN(2);
    chk("R5 enhBits gated", enhBits, 0);
    chk("R5 dout gated", dout, 0);
    enhEnN = 1'b0; waitN(2);
    chk("R5 enhBits restored", enhBits, 8'h40);

    // R6: direct mode and bypass masking
    sendEnh(8'h80);
    chk("R6 bypass visible in serial mode", enhBits, 8'h80);
    pinR = 6'h1B; pinM = 9'h0C3; pinA = 4'hA;
    directMode = 1'b1; waitN(2);
    chk("R6 fields from pins", {divR, divM, divA}, {6'h1B, 9'h0C3, 4'hA});
    chk("R6 bypass masked", enhBits, 8'h00);
    directMode = 1'b0; waitN(2);
    chk("R6 serial fields back", {divR, divM, divA}, prevFields);
    chk("R6 bypass back", enhBits, 8'h80);

    // R7: conflicting and single selections
    fpIn = 1'b1; mselIn = 1'b1; fcIn = 1'b0;
    sendEnh(8'h24);
    chk("R7 two sources drive low", dout, 0);
    sendEnh(8'h20);
    chk("R7 msel selected high", dout, 1);
    mselIn = 1'b0; waitN(1);
    chk("R7 msel selected low", dout, 0);

    // R9: extra leading bits fall off
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1);
    sendFreq(encodeBits(6'h0D, 9'h133, 4'h5));
    pulseLatch();
    chk("R9 last 20 bits kept", {divR, divM, divA}, {6'h0D, 9'h133, 4'h5});

    // R8: latch and shift in the same cycle
    b = encodeBits(6'h2A, 9'h155, 4'h9);
    sendFreq(b);
    @(negedge clk); serData = 1'b1;
    waitN(2); serClk = 1'b1; freqLatch = 1'b1;
    waitN(2); serClk = 1'b0; freqLatch = 1'b0;
    waitN(3);
    chk("R8 commit uses pre-shift buffer", {divR, divM, divA}, {6'h2A, 9'h155, 4'h9});
    pulseLatch();
    e19 = decodeBits({1'b1, b[19:1]});
    chk("R8 shift still applied", {divR, divM, divA}, e19);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    waitN(2);
    chk("R1 fields cleared by reset", {divR, divM, divA}, 0);
    chk("R1 options cleared by reset", enhBits, 0);
    rstN = 1'b1; waitN(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule